// File: doc/BRIEF.md
# GPIO Line Input Conditioner with Interrupt Detection

This block is the receive half of one general-purpose I/O line. It takes the raw pin, passes it through a two-flop synchronizer, optionally inverts it, and cleans it with a programmable glitch filter. The filter is built from a power-of-two clock prescaler and a hold counter. The cleaned, polarity-adjusted level drives an interrupt detector. The detector runs in edge or level mode and keeps a pending flag and an enable flag. Software changes these flags through a small command port. Each command bit either sets or clears one flag; a zero bit does nothing.

Because the inversion sits ahead of both the filter and the detector, one rising-edge / active-high detector also covers falling-edge and active-low triggers. Software only flips the polarity bit. The interrupt request is the pending flag, qualified by the enable flag and by the interrupt-enable bit of the configuration word.

Top module: `gpin_line`

## Requirements
- R1: After reset, `level_o`, `pending_o`, `enable_o` and `irq_o` are all 0.
- R2: The glitch filter uses count = `cfg_i[7:4]` and select = `cfg_i[11:8]`. It produces one tick every 2^select clocks. `level_o` takes a new input value only after that value has been present for count+1 ticks in a row. With select=0, a pin change shows on `level_o` count+3 clock edges later, counting the two synchronizer stages.
- R3: A pin pulse that lasts fewer than count+1 ticks is dropped and never reaches `level_o`. A pulse of exactly count+1 ticks does reach it.
- R4: `cfg_i[1]`=1 inverts the synchronized pin ahead of the filter, so `level_o` follows the complement of the pin.
- R5: In edge mode (`cfg_i[3]`=1), a 0-to-1 change of `level_o` sets `pending_o` one clock later. A 1-to-0 change sets nothing.
- R6: In level mode (`cfg_i[3]`=0), `pending_o` is set on every clock in which `level_o` is 1. An acknowledge has no effect while `level_o` stays 1. Once `level_o` has returned to 0, `pending_o` stays set until it is acknowledged.
- R7: A command write (`cmd_we_i`=1) acts on the pending flag through two bits. Bit 0 set to 1 clears it and bit 1 set to 1 sets it. If both are 1, set wins. Zero bits change nothing.
- R8: A command write acts on the enable flag through two bits. Bit 3 set to 1 sets it and bit 2 set to 1 clears it. If both are 1, clear wins.
- R9: `irq_o` is 1 exactly when `pending_o`, `enable_o` and `cfg_i[2]` are all 1.
- R10: When `cfg_i[2]`=0, the detector never sets `pending_o`. A software set through bit 1 still works.
- R11: One write with bits 0 and 2 both set clears pending and enable together, so `irq_o` drops on the next clock.
- R12: The default input setting (select=4, count=9) delays a pin change by 147 to 162 clock edges. The exact figure depends on the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Raw asynchronous pin sample |
| cfg_i | input | 12 | Line configuration: [1] invert, [2] interrupt enable, [3] edge mode, [7:4] filter count, [11:8] filter select; [0] unused here |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 4 | Command bits: [0] clear pending, [1] set pending, [2] clear enable, [3] set enable |
| level_o | output | 1 | Filtered, polarity-adjusted line level |
| pending_o | output | 1 | Interrupt pending flag |
| enable_o | output | 1 | Interrupt enable flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench measures filter latency edge by edge. An off-by-one in the hold counter or a synchronizer with a missing or extra stage moves the first cycle in which the level changes. A pulse one tick short of the threshold and a pulse exactly at it show whether the filter rejects or admits at the boundary. A design that fails to reset the hold counter on a bounce would let the short pulse through. Edge mode is checked for a set on the falling edge, and level mode for an acknowledge that wrongly takes effect while the level is still high. Commands that set and clear the same flag at once check the chosen priority. Writes of all zeros must leave both flags unchanged.

// File: rtl/gpin_pkg.sv
package gpin_pkg;

  localparam int CFG_W    = 12;
  localparam int FCNT_LSB = 4;
  localparam int FCNT_W   = 4;
  localparam int FSEL_LSB = 8;
  localparam int FSEL_W   = 4;
  localparam int INV_BIT  = 1;
  localparam int IEN_BIT  = 2;
  localparam int EDGE_BIT = 3;
  localparam int PRE_W    = (1 << FSEL_W) - 1;
  localparam int CMD_W    = 4;

  typedef enum logic {
    DET_LEVEL = 1'b0,
    DET_EDGE  = 1'b1
  } det_mode_e;

  typedef struct packed {
    det_mode_e          mode;
    logic               irq_en;
    logic               invert;
    logic [FSEL_W-1:0]  fsel;
    logic [FCNT_W-1:0]  fcnt;
  } line_cfg_t;

  typedef struct packed {
    logic ack;     // clear pending
    logic pset;    // set pending
    logic mask;    // clear enable
    logic unmask;  // set enable
  } line_cmd_t;

  function automatic line_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
    line_cfg_t c;
    c.mode   = w[EDGE_BIT] ? DET_EDGE : DET_LEVEL;
    c.irq_en = w[IEN_BIT];
    c.invert = w[INV_BIT];
    c.fsel   = w[FSEL_LSB +: FSEL_W];
    c.fcnt   = w[FCNT_LSB +: FCNT_W];
    return c;
  endfunction

  function automatic line_cmd_t decode_cmd(input logic we, input logic [CMD_W-1:0] d);
    line_cmd_t k;
    k.ack    = we & d[0];
    k.pset   = we & d[1];
    k.mask   = we & d[2];
    k.unmask = we & d[3];
    return k;
  endfunction

  // Low-bit mask that marks one prescaler period of 2^sel clocks.
  function automatic logic [PRE_W-1:0] tick_mask(input logic [FSEL_W-1:0] sel);
    logic [31:0] one;
    logic [31:0] m;
    one = 32'd1;
    m   = (one << sel) - 32'd1;
    return m[PRE_W-1:0];
  endfunction

  // True once the hold counter has seen count+1 ticks (this tick included).
  function automatic logic hold_done(input logic [FCNT_W-1:0] hold,
                                     input logic [FCNT_W-1:0] cnt);
    return hold >= cnt;
  endfunction

endpackage

// File: rtl/gpin_sync.sv
module gpin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpin_filter.sv
module gpin_filter
  import gpin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_i,
  input  logic [FSEL_W-1:0] fsel_i,
  input  logic [FCNT_W-1:0] fcnt_i,
  output logic              level_o,
  output logic              tick_o,
  output logic              commit_o
);
  logic [PRE_W-1:0]  pre_q;
  logic [PRE_W-1:0]  mask;
  logic [FCNT_W-1:0] hold_q;
  logic              level_q;
  logic              differ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign mask     = tick_mask(fsel_i);
  assign tick_o   = (pre_q & mask) == mask;
  assign differ   = raw_i ^ level_q;
  assign commit_o = differ & tick_o & hold_done(hold_q, fcnt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      level_q <= 1'b0;
    end else if (!differ) begin
      hold_q  <= '0;
    end else if (commit_o) begin
      hold_q  <= '0;
      level_q <= raw_i;
    end else if (tick_o) begin
      hold_q  <= hold_q + 1'b1;
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/gpin_detect.sv
module gpin_detect
  import gpin_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      level_i,
  input  det_mode_e mode_i,
  input  logic      irq_en_i,
  input  line_cmd_t cmd_i,
  output logic      pending_o,
  output logic      enable_o,
  output logic      rise_o,
  output logic      hw_set_o
);
  logic level_d1_q;
  logic pend_q;
  logic en_q;
  logic pend_d;
  logic en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_d1_q <= 1'b0;
    else        level_d1_q <= level_i;
  end

  assign rise_o   = level_i & ~level_d1_q;
  assign hw_set_o = irq_en_i & ((mode_i == DET_EDGE) ? rise_o : level_i);

  always_comb begin
    pend_d = hw_set_o | cmd_i.pset | (pend_q & ~cmd_i.ack);
    if (cmd_i.mask)        en_d = 1'b0;
    else if (cmd_i.unmask) en_d = 1'b1;
    else                   en_d = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

  assign pending_o = pend_q;
  assign enable_o  = en_q;
endmodule

// File: rtl/gpin_line.sv
module gpin_line
  import gpin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             level_o,
  output logic             pending_o,
  output logic             enable_o,
  output logic             irq_o
);
  line_cfg_t cfg_dec;
  line_cmd_t cmd_dec;
  logic      pin_sync;
  logic      pin_pol;
  logic      flt_tick;
  logic      flt_commit;
  logic      det_rise;
  logic      det_hw_set;

  assign cfg_dec = decode_cfg(cfg_i);
  assign cmd_dec = decode_cmd(cmd_we_i, cmd_i);

  gpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  assign pin_pol = pin_sync ^ cfg_dec.invert;

  gpin_filter u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_i    (pin_pol),
    .fsel_i   (cfg_dec.fsel),
    .fcnt_i   (cfg_dec.fcnt),
    .level_o  (level_o),
    .tick_o   (flt_tick),
    .commit_o (flt_commit)
  );

  gpin_detect u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_i   (level_o),
    .mode_i    (cfg_dec.mode),
    .irq_en_i  (cfg_dec.irq_en),
    .cmd_i     (cmd_dec),
    .pending_o (pending_o),
    .enable_o  (enable_o),
    .rise_o    (det_rise),
    .hw_set_o  (det_hw_set)
  );

  assign irq_o = pending_o & enable_o & cfg_dec.irq_en;
endmodule

// File: rtl/gpin_line_chk.sv
module gpin_line_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_we,
  input logic [3:0] cmd,
  input logic       ien,
  input logic       edge_mode,
  input logic       level,
  input logic       pending,
  input logic       enable,
  input logic       irq,
  input logic       tick,
  input logic       commit,
  input logic       hw_set
);
  assert_level_on_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> ($past(commit) && $past(tick)));

  assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ien && edge_mode && $rose(level)) |=> pending);

  assert_level_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ien && !edge_mode && level) |=> pending);

  assert_w1s_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd[1]) |=> pending);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd[0] && !cmd[1] && !hw_set) |=> !pending);

  assert_pending_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !(cmd_we && cmd[0])) |=> pending);

  assert_unmask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd[3] && !cmd[2]) |=> enable);

  assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd[2]) |=> !enable);

  assert_irq_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pending && enable && ien));

  assert_no_hw_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien && !pending && !(cmd_we && cmd[1])) |=> !pending);
endmodule

bind gpin_line gpin_line_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_we    (cmd_we_i),
  .cmd       (cmd_i),
  .ien       (cfg_dec.irq_en),
  .edge_mode (cfg_dec.mode == gpin_pkg::DET_EDGE),
  .level     (level_o),
  .pending   (pending_o),
  .enable    (enable_o),
  .irq       (irq_o),
  .tick      (flt_tick),
  .commit    (flt_commit),
  .hw_set    (det_hw_set)
);

// File: tb/sim_gpin_line.sv
module sim_gpin_line;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [11:0] cfg = '0;
  logic        we = 1'b0;
  logic [3:0]  cmd = '0;
  logic        level, pending, enable, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpin_line u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .cfg_i(cfg),
    .cmd_we_i(we), .cmd_i(cmd),
    .level_o(level), .pending_o(pending), .enable_o(enable), .irq_o(irq)
  );

  // cfg: [1] invert, [2] irq enable, [3] edge, [7:4] count, [11:8] select
  function automatic logic [11:0] mk(input int sel, input int cnt, input bit edg,
                                     input bit ien, input bit inv);
    logic [11:0] w;
    w = '0;
    w[11:8] = sel[3:0];
    w[7:4]  = cnt[3:0];
    w[3]    = edg;
    w[2]    = ien;
    w[1]    = inv;
    return w;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] c);
    @(negedge clk);
    we = 1'b1; cmd = c;
    @(negedge clk);
    we = 1'b0; cmd = '0;
  endtask

  // number of edges until level reaches target, 0 if never within limit
  task automatic latency(input logic target, input int limit, output int k_out);
    k_out = 0;
    for (int k = 1; k <= limit; k++) begin
      step(1);
      if (level == target && k_out == 0) k_out = k;
    end
  endtask

  task automatic t_reset;
    chk("R1", "level", level, 0);
    chk("R1", "pending", pending, 0);
    chk("R1", "enable", enable, 0);
    chk("R1", "irq", irq, 0);
  endtask

  task automatic t_filter_latency;
    int k;
    cfg = mk(0, 5, 0, 0, 0);
    step(4);
    pin = 1'b1;
    latency(1'b1, 30, k);
    chk("R2", "rise latency count=5", k, 8);
    pin = 1'b0;
    latency(1'b0, 30, k);
    chk("R2", "fall latency count=5", k, 8);
    cfg = mk(0, 0, 0, 0, 0);
    step(2);
    pin = 1'b1;
    latency(1'b1, 30, k);
    chk("R2", "rise latency count=0", k, 3);
    pin = 1'b0;
    step(10);
  endtask

  task automatic t_glitch;
    int seen;
    cfg = mk(0, 5, 0, 0, 0);
    step(4);
    seen = 0;
    pin = 1'b1; step(5); pin = 1'b0;
    for (int k = 0; k < 20; k++) begin step(1); if (level) seen = 1; end
    chk("R3", "5-cycle pulse dropped", seen, 0);
    seen = 0;
    pin = 1'b1; step(6); pin = 1'b0;
    for (int k = 0; k < 20; k++) begin step(1); if (level) seen = 1; end
    chk("R3", "6-cycle pulse passed", seen, 1);
    step(10);
  endtask

  task automatic t_invert;
    cfg = mk(0, 0, 0, 0, 1);
    pin = 1'b0;
    step(6);
    chk("R4", "inverted low pin", level, 1);
    pin = 1'b1;
    step(6);
    chk("R4", "inverted high pin", level, 0);
    cfg = mk(0, 0, 0, 0, 0);
    pin = 1'b0;
    step(6);
  endtask

  task automatic t_default_filter;
    int k;
    cfg = mk(4, 9, 0, 0, 0);
    step(4);
    pin = 1'b1;
    latency(1'b1, 200, k);
    chk("R12", "default latency in range", int'(k >= 147 && k <= 162), 1);
    pin = 1'b0;
    latency(1'b0, 200, k);
    chk("R12", "default fall latency in range", int'(k >= 147 && k <= 162), 1);
    cfg = mk(0, 0, 0, 0, 0);
    step(4);
  endtask

  task automatic t_edge;
    cfg = mk(0, 0, 1, 1, 0);
    wr(4'b1000);
    chk("R8", "unmask", enable, 1);
    step(2);
    pin = 1'b1;
    step(3);
    chk("R5", "level up at edge 3", level, 1);
    chk("R5", "pending not yet", pending, 0);
    step(1);
    chk("R5", "pending one clock later", pending, 1);
    chk("R9", "irq raised", irq, 1);
    wr(4'b0001);
    chk("R5", "ack while high in edge mode", pending, 0);
    pin = 1'b0;
    step(8);
    chk("R5", "falling edge no set", pending, 0);
  endtask

  task automatic t_level;
    cfg = mk(0, 0, 0, 1, 0);
    step(2);
    chk("R6", "low level no set", pending, 0);
    pin = 1'b1;
    step(6);
    chk("R6", "high level sets", pending, 1);
    wr(4'b0001);
    chk("R6", "ack ignored while high", pending, 1);
    pin = 1'b0;
    step(8);
    chk("R6", "stays after level drops", pending, 1);
    wr(4'b0001);
    chk("R6", "ack after low", pending, 0);
  endtask

  task automatic t_soft;
    cfg = mk(0, 0, 1, 0, 0);
    pin = 1'b1;
    step(8);
    chk("R10", "no hw set with ien=0", pending, 0);
    pin = 1'b0;
    step(6);
    wr(4'b0010);
    chk("R7", "w1s pending", pending, 1);
    chk("R9", "irq gated by cfg bit2", irq, 0);
    wr(4'b0000);
    chk("R7", "zero write keeps pending", pending, 1);
    wr(4'b0011);
    chk("R7", "set wins over clear", pending, 1);
    wr(4'b0001);
    chk("R7", "w1c pending", pending, 0);
  endtask

  task automatic t_enable;
    wr(4'b0000);
    chk("R8", "zero write keeps enable", enable, 1);
    wr(4'b1100);
    chk("R8", "clear wins over set", enable, 0);
    wr(4'b1000);
    chk("R8", "set enable", enable, 1);
    wr(4'b0100);
    chk("R8", "clear enable", enable, 0);
  endtask

  task automatic t_mask_ack;
    cfg = mk(0, 0, 1, 1, 0);
    wr(4'b1010);
    chk("R9", "irq with all three", irq, 1);
    cfg = mk(0, 0, 1, 0, 0);
    step(1);
    chk("R9", "irq off with cfg bit2=0", irq, 0);
    cfg = mk(0, 0, 1, 1, 0);
    step(1);
    chk("R9", "irq back", irq, 1);
    wr(4'b0101);
    chk("R11", "pending cleared", pending, 0);
    chk("R11", "enable cleared", enable, 0);
    chk("R11", "irq dropped", irq, 0);
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_filter_latency();
    t_glitch();
    t_invert();
    t_default_filter();
    t_edge();
    t_level();
    t_soft();
    wr(4'b1000);
    t_enable();
    t_mask_ack();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule